// File: doc/BRIEF.md
# Three-Wire Addressed Configuration Receiver

This block takes a slow three-wire serial stream (serial clock, serial data and an active-low frame enable) and loads one of two configuration words from it. While the frame enable is low, each rising edge of the serial clock shifts one data bit in, most significant bit first. When the enable returns high, the bit received last is read as an address. Address 1 writes the 23 bits received before it into the wide word, which holds divider codes, polarity, phase, power and current-scaling fields. Address 0 writes the 11 bits received before it into the narrow word, which holds demodulator tuning, compensation current and test selection.

All three bus lines are asynchronous to the system clock. Each passes through a two-stage synchronizer, and edges are detected in the system clock domain. The bus must therefore be slow compared with the system clock: at least a few system cycles per bus half-period and between frames. Surplus leading bits are dropped, and the number of clocks in a frame is never checked.

A standby input with a retention input decides whether the words survive standby. If retention is low during standby, both words clear. If retention is high, they are kept. The block has no streaming interface. Every pin is a plain control or status level, so there is no back-pressure.

Top module: `cfg3w_rx`

## Requirements
- R1: Data is sampled only on a rising edge of `bus_clk` while `bus_en_n` is low, and bits arrive most significant first.
- R2: On a rising edge of `bus_en_n` with last bit 1, `word_a[22:0]` takes the 23 bits received before the address. `word_a[22]` is the earliest of those bits and `word_a[0]` is the one just before the address.
- R3: On a rising edge of `bus_en_n` with last bit 0, `word_b[10:0]` takes the 11 bits received before the address. `word_b[10]` is the earliest of those bits.
- R4: Bits received ahead of the word length plus the address are discarded, and any clock count is accepted.
- R5: A frame addressed to one word leaves the other word unchanged.
- R6: `bus_clk` edges while `bus_en_n` is high do not change the shift contents. A later frame with no clocks reloads the word selected by the previous frame's address bit with that frame's bits.
- R7: While `standby` is high and `hold_en` is low, both words are zero from the next cycle onward, and this takes priority over a load.
- R8: While `standby` and `hold_en` are both high, and no frame ends, both words keep their values.
- R9: After `rst_n` is released, both words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Serial bus clock (asynchronous) |
| bus_data | input | 1 | Serial bus data (asynchronous) |
| bus_en_n | input | 1 | Active-low frame enable (asynchronous) |
| standby | input | 1 | Standby request |
| hold_en | input | 1 | Keep words through standby when high |
| word_a | output | 23 | Wide configuration word (address 1) |
| word_b | output | 11 | Narrow configuration word (address 0) |

## Verification
The bench sends frames that are exactly as long as the word plus the address, and also frames with many surplus leading bits. A design that counted bits, or took the first bits instead of the last ones, would load shifted or garbage values. The bench also toggles the serial clock with the enable high and then closes an empty frame. A design that shifted outside a frame would then reload the wrong data, or load the wrong word. Standby is exercised with retention high and with retention low, which catches a clear that is ignored or a hold that loses data. Each load is checked against both words, so a write that leaks into the unselected word is seen.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
  localparam int unsigned WIDE_W   = 23;
  localparam int unsigned NARROW_W = 11;
  localparam int unsigned SYNC_N   = 2;
endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int unsigned CW = W * STAGES;
  logic [CW-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= INIT;
        else        chain <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= {STAGES{INIT}};
        else        chain <= {chain[CW-W-1:0], din};
    end
  endgenerate

  assign dout = chain[CW-1 -: W];
endmodule

// File: rtl/cfg3w_shift.sv
module cfg3w_shift #(
  parameter int unsigned SR_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk_s,
  input  logic            sdat_s,
  input  logic            sen_s,
  output logic [SR_W-1:0] sr,
  output logic            ld_a,
  output logic            ld_b
);
  logic sclk_q, sen_q;
  logic clk_rise, en_rise;

  assign clk_rise = sclk_s & ~sclk_q;
  assign en_rise  = sen_s & ~sen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sen_q  <= 1'b1;
      sr     <= '0;
    end else begin
      sclk_q <= sclk_s;
      sen_q  <= sen_s;
      if (clk_rise && !sen_s)
        sr <= {sr[SR_W-2:0], sdat_s};
    end
  end

  // last bit of the frame selects the destination
  assign ld_a = en_rise &  sr[0];
  assign ld_b = en_rise & ~sr[0];
endmodule

// File: rtl/cfg3w_bank.sv
module cfg3w_bank #(
  parameter int unsigned A_W = 23,
  parameter int unsigned B_W = 11,
  parameter int unsigned SR_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_a,
  input  logic            ld_b,
  input  logic [SR_W-1:0] sr,
  input  logic            standby,
  input  logic            hold_en,
  output logic [A_W-1:0]  word_a,
  output logic [B_W-1:0]  word_b
);
  logic drop;
  assign drop = standby & ~hold_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_a <= '0;
      word_b <= '0;
    end else if (drop) begin
      word_a <= '0;
      word_b <= '0;
    end else begin
      if (ld_a) word_a <= sr[A_W:1];
      if (ld_b) word_b <= sr[B_W:1];
    end
  end
endmodule

// File: rtl/cfg3w_rx.sv
module cfg3w_rx
  import cfg3w_pkg::*;
#(
  parameter int unsigned A_W = WIDE_W,
  parameter int unsigned B_W = NARROW_W,
  parameter int unsigned SYNC_STAGES = SYNC_N
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_clk,
  input  logic           bus_data,
  input  logic           bus_en_n,
  input  logic           standby,
  input  logic           hold_en,
  output logic [A_W-1:0] word_a,
  output logic [B_W-1:0] word_b
);
  localparam int unsigned MAX_W = (A_W > B_W) ? A_W : B_W;
  localparam int unsigned SR_W  = MAX_W + 1;

  logic [2:0]      raw_s;
  logic            sclk_s, sdat_s, en_s;
  logic [SR_W-1:0] sr;
  logic            ld_a, ld_b;

  cfg3w_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({bus_en_n, bus_data, bus_clk}),
    .dout(raw_s)
  );
  assign {en_s, sdat_s, sclk_s} = raw_s;

  cfg3w_shift #(.SR_W(SR_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .sdat_s(sdat_s), .sen_s(en_s),
    .sr(sr), .ld_a(ld_a), .ld_b(ld_b)
  );

  cfg3w_bank #(.A_W(A_W), .B_W(B_W), .SR_W(SR_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .ld_a(ld_a), .ld_b(ld_b), .sr(sr),
    .standby(standby), .hold_en(hold_en),
    .word_a(word_a), .word_b(word_b)
  );
endmodule

// File: rtl/cfg3w_chk.sv
module cfg3w_chk #(
  parameter int unsigned A_W = 23,
  parameter int unsigned B_W = 11,
  parameter int unsigned SR_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_s,
  input logic            ld_a,
  input logic            ld_b,
  input logic            standby,
  input logic            hold_en,
  input logic [SR_W-1:0] sr,
  input logic [A_W-1:0]  word_a,
  input logic [B_W-1:0]  word_b
);
  AST_A_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_a) |-> $past(ld_a || (standby && !hold_en))); // R2

  AST_B_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_b) |-> $past(ld_b || (standby && !hold_en))); // R3

  AST_A_SPARES_B: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_a && !(standby && !hold_en)) |=> $stable(word_b)); // R5

  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_s) |-> $stable(sr)); // R6

  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !hold_en) |=> (word_a == '0 && word_b == '0)); // R7

  AST_RETAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && hold_en && !ld_a && !ld_b) |=> ($stable(word_a) && $stable(word_b))); // R8
endmodule

bind cfg3w_rx cfg3w_chk #(.A_W(A_W), .B_W(B_W), .SR_W(SR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_s(en_s), .ld_a(ld_a), .ld_b(ld_b),
  .standby(standby), .hold_en(hold_en), .sr(sr),
  .word_a(word_a), .word_b(word_b)
);

// File: tb/sim_cfg3w_rx.sv
module sim_cfg3w_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_clk = 1'b0, bus_data = 1'b0, bus_en_n = 1'b1;
  logic standby = 1'b0, hold_en = 1'b0;
  logic [22:0] word_a;
  logic [10:0] word_b;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [22:0] exp_a_q[$];
  logic [10:0] exp_b_q[$];
  string tag_q[$];
  event chk_ev;
  logic [22:0] cur_a = '0;
  logic [10:0] cur_b = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg3w_rx u0 (.clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data),
               .bus_en_n(bus_en_n), .standby(standby), .hold_en(hold_en),
               .word_a(word_a), .word_b(word_b));

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push_exp(input string tag);
    exp_a_q.push_back(cur_a);
    exp_b_q.push_back(cur_b);
    tag_q.push_back(tag);
    ->chk_ev;
    wait_cyc(3);
  endtask

  task automatic send(input logic [63:0] bits, input int n);
    @(negedge clk); bus_en_n = 1'b0;
    wait_cyc(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      bus_data = bits[i];
      wait_cyc(HALF);
      bus_clk = 1'b1;
      wait_cyc(HALF);
      bus_clk = 1'b0;
    end
    wait_cyc(HALF);
    bus_en_n = 1'b1;
    wait_cyc(12);
  endtask

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      @(chk_ev);
      @(negedge clk);
      begin
        string t;
        logic [22:0] ea;
        logic [10:0] eb;
        t = tag_q.pop_front();
        ea = exp_a_q.pop_front();
        eb = exp_b_q.pop_front();
        cmp({t, " word_a"}, {9'd0, word_a}, {9'd0, ea});
        cmp({t, " word_b"}, {21'd0, word_b}, {21'd0, eb});
      end
    end
  end

  initial begin : watchdog
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    push_exp("R9 reset");

    // R1 R2 exact-length wide frame, R5 narrow untouched
    send({40'd0, 23'h5A3C71, 1'b1}, 24);
    cur_a = 23'h5A3C71;
    push_exp("R1 R2 R5 wide frame");

    // R3 narrow frame, R5 wide untouched
    send({52'd0, 11'h6B5, 1'b0}, 12);
    cur_b = 11'h6B5;
    push_exp("R3 R5 narrow frame");

    // R4 surplus leading bits before a wide word
    send({33'd0, 7'h55, 23'h12ABCD, 1'b1}, 31);
    cur_a = 23'h12ABCD;
    push_exp("R4 wide with extra bits");

    // R4 surplus leading bits before a narrow word
    send({39'd0, 13'h1FFF, 11'h0A3, 1'b0}, 25);
    cur_b = 11'h0A3;
    push_exp("R4 narrow with extra bits");

    // R6 clocks with enable high, then an empty frame reloads last narrow data
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      bus_data = i[0];
      wait_cyc(HALF); bus_clk = 1'b1;
      wait_cyc(HALF); bus_clk = 1'b0;
    end
    wait_cyc(HALF);
    send(64'd0, 0);
    push_exp("R6 idle clocks ignored");

    // R8 retention through standby
    @(negedge clk); standby = 1'b1; hold_en = 1'b1;
    wait_cyc(10);
    push_exp("R8 standby hold");
    standby = 1'b0;

    // R7 clear through standby without hold
    @(negedge clk); hold_en = 1'b0; standby = 1'b1;
    wait_cyc(3);
    cur_a = '0; cur_b = '0;
    push_exp("R7 standby clear");
    standby = 1'b0;

    // R2 reload after clear, all ones pattern
    send({40'd0, 23'h7FFFFF, 1'b1}, 24);
    cur_a = 23'h7FFFFF;
    push_exp("R2 reload after clear");

    wait_cyc(5);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule